// File: doc/BRIEF.md
# Power-up configuration word loader

This block fetches a single 16-bit configuration word once after reset and presents it, unchanged, for the rest of operation. A three-state mode strap selects the source of the word. Analog detection of the floating strap level is handled outside the logic, so the block receives two decoded inputs: `mode_float` and `mode_high`.

With the strap floating, the block acts as master of a 3-wire serial EEPROM. It drives its own serial clock, which is the system clock divided by a parameter. It holds chip select for the whole transfer and shifts out a read frame. The frame is a start bit, a read opcode and an address. The EEPROM returns a dummy bit and then sixteen data bits. With the strap driven high, a neighbouring controller supplies the serial clock, and the block captures the first sixteen data bits it sees. With the strap driven low, nothing is transferred and a fixed default word is applied. In every mode the first bit received becomes bit 0 of the word. When loading finishes, `cfg_done` rises and the word is frozen.

Top module: `cfg_loader`

## Requirements
- R1: While reset is asserted, and after reset until loading completes, `cfg_word` is 0. During reset, `cfg_done`, `ee_cs` and `ee_sclk` are also 0.
- R2: The strap inputs are read only on the first clock edge after reset release. Later changes to them have no effect on the source or on the result.
- R3: With both strap inputs low, `cfg_word` takes DEFAULT_WORD and `cfg_done` is 1 within two clock edges after reset release. With the default, DEFAULT_WORD is 0x0000. In that word bits [4:0] are the station address (00000), bit 5 is the isolate-disable bit (0) and bit 6 is the repeater bit (0).
- R4: In floating mode `ee_cs` stays high from the start to the end of the transfer. Each `ee_sclk` period is low for CLK_DIV clocks and then high for CLK_DIV clocks. Exactly 26 rising edges occur.
- R5: In floating mode, `ee_cmd` sampled at the first nine `ee_sclk` rising edges reads 1, 1, 0 and then the 6-bit ADDR, MSB first. With the default ADDR, the bits are 110000000.
- R6: In floating mode, `ser_din` is sampled at the end of each high phase. The value after rising edge 10 is a dummy bit and is ignored. The values after rising edges 11 to 26 become word bits 0 to 15, so the least significant bit comes first.
- R7: After the 26th bit, `ee_cs` and `ee_sclk` return low and stay low. `cfg_done` rises.
- R8: In externally clocked mode, `ser_din` is captured on each rising edge of `ext_sclk`, with the first edge giving bit 0. `cfg_done` rises after the 16th edge. Edges must be at least three clocks apart.
- R9: Once `cfg_done` is high, it stays high. `cfg_word` then stays unchanged, and further `ext_sclk` edges and `ser_din` activity have no effect.
- R10: Outside floating mode, `ee_cs` and `ee_sclk` never go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| mode_float | input | 1 | Decoded strap: floating, EEPROM master mode |
| mode_high | input | 1 | Decoded strap level when not floating: 1 external clock, 0 defaults |
| ext_sclk | input | 1 | Externally driven serial clock (asynchronous) |
| ser_din | input | 1 | Serial data in from EEPROM or controller |
| ee_sclk | output | 1 | Generated serial clock to EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_cmd | output | 1 | Serial read command to EEPROM |
| cfg_word | output | 16 | Loaded configuration word |
| cfg_done | output | 1 | Loading complete |

## Verification
A bit counter that is off by one shifts every captured bit, so the whole word comes out rotated or with the dummy bit in it. This shows at `cfg_done`, one transfer after reset. If the divider or phase state is wrong, the `ee_sclk` period or the edge count is wrong at the very first EEPROM bit. A corrupted command register shows on `ee_cmd` within the first nine edges. A state machine that leaves its final state shows as `cfg_word` changing, or as a fresh strobe on `ee_cs`, after `cfg_done`. The bench drives a 1 on the dummy position, and drives extra external edges after completion, so that both of these faults become visible.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int WORD_W = 16,
  parameter int CLK_DIV = 4,
  parameter int ADDR_W = 6,
  parameter logic [5:0] ADDR = 6'd0,
  parameter logic [15:0] DEFAULT_WORD = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_float,
  input  logic              mode_high,
  input  logic              ext_sclk,
  input  logic              ser_din,
  output logic              ee_sclk,
  output logic              ee_cs,
  output logic              ee_cmd,
  output logic [WORD_W-1:0] cfg_word,
  output logic              cfg_done
);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int FIRST_DATA = CMD_W + 1;
  localparam int LAST_BIT = FIRST_DATA + WORD_W - 1;
  localparam int IDX_W = $clog2(LAST_BIT + 1);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CMD_W-1:0] FRAME = {3'b110, ADDR[ADDR_W-1:0]};

  typedef enum logic [1:0] {S_INIT, S_EE, S_EXT, S_DONE} state_t;
  state_t st;

  logic [DIV_W-1:0]  div_cnt;
  logic              phase_hi;
  logic [IDX_W-1:0]  bit_idx;
  logic [CMD_W-1:0]  cmd_sh;
  logic [WORD_W-1:0] shreg, cfg_q;
  logic [CNT_W-1:0]  ext_cnt;
  logic [2:0]        sclk_sync;
  logic [1:0]        din_sync;
  logic              cs_q, sclk_q, done_q;

  wire ext_rise  = sclk_sync[1] & ~sclk_sync[2];
  wire div_wrap  = (div_cnt == DIV_W'(CLK_DIV - 1));
  wire [WORD_W-1:0] ee_next  = {ser_din, shreg[WORD_W-1:1]};
  wire [WORD_W-1:0] ext_next = {din_sync[1], shreg[WORD_W-1:1]};

  assign ee_sclk  = sclk_q;
  assign ee_cs    = cs_q;
  assign ee_cmd   = cmd_sh[CMD_W-1] & cs_q;
  assign cfg_word = cfg_q;
  assign cfg_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      din_sync  <= '0;
    end else begin
      sclk_sync <= {sclk_sync[1:0], ext_sclk};
      din_sync  <= {din_sync[0], ser_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_INIT;
      div_cnt  <= '0;
      phase_hi <= 1'b0;
      bit_idx  <= '0;
      cmd_sh   <= '0;
      shreg    <= '0;
      cfg_q    <= '0;
      ext_cnt  <= '0;
      cs_q     <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      case (st)
        S_INIT: begin
          if (mode_float) begin
            st     <= S_EE;
            cs_q   <= 1'b1;
            cmd_sh <= FRAME;
          end else if (mode_high) begin
            st <= S_EXT;
          end else begin
            cfg_q  <= DEFAULT_WORD[WORD_W-1:0];
            done_q <= 1'b1;
            st     <= S_DONE;
          end
        end
        S_EE: begin
          if (!div_wrap) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            if (!phase_hi) begin
              phase_hi <= 1'b1;
              sclk_q   <= 1'b1;
            end else begin
              phase_hi <= 1'b0;
              sclk_q   <= 1'b0;
              cmd_sh   <= cmd_sh << 1;
              if (bit_idx >= IDX_W'(FIRST_DATA))
                shreg <= ee_next;
              if (bit_idx == IDX_W'(LAST_BIT)) begin
                cs_q   <= 1'b0;
                cfg_q  <= ee_next;
                done_q <= 1'b1;
                st     <= S_DONE;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
        end
        S_EXT: begin
          if (ext_rise) begin
            shreg <= ext_next;
            if (ext_cnt == CNT_W'(WORD_W - 1)) begin
              cfg_q  <= ext_next;
              done_q <= 1'b1;
              st     <= S_DONE;
            end else begin
              ext_cnt <= ext_cnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ee_sclk,
  input logic              ee_cs,
  input logic              ee_cmd,
  input logic [WORD_W-1:0] cfg_word,
  input logic              cfg_done
);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  a_r9_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> $stable(cfg_word));

  a_r1_word_zero_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> cfg_word == '0);

  a_r4_sclk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sclk);

  a_r5_cmd_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_cmd);

  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !ee_cs && !ee_sclk);
endmodule

bind cfg_loader cfg_loader_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ee_sclk(ee_sclk), .ee_cs(ee_cs),
  .ee_cmd(ee_cmd), .cfg_word(cfg_word), .cfg_done(cfg_done));

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic mode_float = 0, mode_high = 0, ext_sclk = 0, ext_din = 0, ee_din = 0, ee_mode = 0;
  wire ser_din = ee_mode ? ee_din : ext_din;
  logic ee_sclk, ee_cs, ee_cmd, cfg_done;
  logic [W-1:0] cfg_word;

  int checks = 0, errors = 0;
  logic [W-1:0] expq[$];
  logic [W-1:0] ee_word = '0;
  int rises = 0, per_bad = 0, cyc = 0, last_rise = 0, cs_seen = 0;
  logic [8:0] cmd_rx = '0;
  logic seen = 0;

  cfg_loader u_cfg_loader (
    .clk(clk), .rst_n(rst_n), .mode_float(mode_float), .mode_high(mode_high),
    .ext_sclk(ext_sclk), .ser_din(ser_din), .ee_sclk(ee_sclk), .ee_cs(ee_cs),
    .ee_cmd(ee_cmd), .cfg_word(cfg_word), .cfg_done(cfg_done));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) begin
    cyc++;
    if (ee_cs) cs_seen++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM model
  always @(posedge ee_sclk) begin
    rises++;
    if (rises >= 2 && (cyc - last_rise) != 2*DIV) per_bad++;
    last_rise = cyc;
    if (rises <= 9) cmd_rx = {cmd_rx[7:0], ee_cmd};
    if (rises == 10) ee_din <= 1'b1;
    else if (rises >= 11 && rises <= 26) ee_din <= ee_word[rises-11];
    else ee_din <= 1'b1;
  end
  always @(negedge ee_sclk) if ((cyc - last_rise) != DIV) per_bad++;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) seen <= 0;
    else if (cfg_done && !seen) begin
      seen <= 1;
      if (expq.size() == 0) check("R6/R8 scoreboard empty", 1, 0);
      else check("R3/R6/R8 loaded word", 32'(cfg_word), 32'(expq.pop_front()));
    end
  end

  task automatic power_up(input logic fl, input logic hi);
    rst_n = 0; mode_float = fl; mode_high = hi; ext_sclk = 0; ext_din = 0;
    ee_mode = fl; rises = 0; per_bad = 0; cs_seen = 0; cmd_rx = '0; ee_din = 0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", 32'(cfg_done), 0);
    check("R1 word in reset", 32'(cfg_word), 0);
    check("R1 cs/sclk in reset", 32'({ee_cs, ee_sclk}), 0);
    rst_n = 1;
  endtask

  task automatic ext_bit(input logic b);
    ext_din = b;
    repeat (3) @(negedge clk);
    ext_sclk = 1;
    repeat (3) @(negedge clk);
    ext_sclk = 0;
  endtask

  task automatic run_ee(input logic [W-1:0] w);
    ee_word = w;
    expq.push_back(w);
    power_up(1, 0);
    @(negedge clk); mode_float = 0; mode_high = 0;
    repeat (40) @(negedge clk);
    check("R1 word zero mid-load", 32'(cfg_word), 0);
    check("R4 cs held mid-load", 32'(ee_cs), 1);
    wait (cfg_done);
    @(negedge clk);
    check("R4 rising edge count", rises, 26);
    check("R4 clock phase lengths", per_bad, 0);
    check("R5 command bits", 32'(cmd_rx), 32'h180);
    check("R7 cs low after load", 32'(ee_cs), 0);
    repeat (50) @(negedge clk);
    check("R7 no further edges", rises, 26);
    check("R9 word held", 32'(cfg_word), 32'(w));
  endtask

  task automatic run_ext(input logic [W-1:0] w);
    expq.push_back(w);
    power_up(0, 1);
    @(negedge clk); mode_float = 1;
    for (int i = 0; i < W; i++) begin
      ext_bit(w[i]);
      if (i == W-2) check("R8 not done before 16th edge", 32'(cfg_done), 0);
    end
    repeat (4) @(negedge clk);
    check("R8 done after 16th edge", 32'(cfg_done), 1);
    for (int i = 0; i < 5; i++) ext_bit(~w[i]);
    repeat (4) @(negedge clk);
    check("R9 later edges ignored", 32'(cfg_word), 32'(w));
    check("R10 no EEPROM activity", rises + cs_seen, 0);
    check("R2 strap change ignored", 32'(cfg_done), 1);
  endtask

  initial begin
    run_ee(16'hA5C3);
    run_ee(16'h8001);
    run_ee(16'h0000);
    run_ext(16'h1234);
    run_ext(16'hFFFE);
    expq.push_back(16'h0000);
    power_up(0, 0);
    @(negedge clk); @(negedge clk);
    check("R3 default done", 32'(cfg_done), 1);
    check("R3 default word", 32'(cfg_word), 0);
    mode_high = 1;
    for (int i = 0; i < 4; i++) ext_bit(1);
    check("R9 default word held", 32'(cfg_word), 0);
    check("R10 no EEPROM activity default", rises + cs_seen, 0);
    check("R3 scoreboard drained", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule